// File: doc/BRIEF.md
# Decoder Control Register Slave on a Two-Wire Serial Bus

This block lets a host controller set up a broadcast audio decoder over a two-wire serial bus (I2C) and read back what the signal detectors have found. It samples the bus clock and data lines with the fast system clock, recognises START, repeated START and STOP, and answers only to its own 7-bit device address 0x42 (address byte 0x84 to write, 0x85 to read). Its data line is open drain: the block only ever asks for the line to be pulled low.

A write carries a sub-address byte and then any number of data bytes. Each data byte goes to the register named by the current sub-address, which then steps on by one, so one transfer can load several registers. The register fields come out as parallel outputs that set the input level, the stereo separation trims, the output mode flags and the two channel volumes. A read returns a status byte built from the stereo, second-audio-program and noise detectors, plus a flag showing that the block has been reset since the host last read it.

Top module: `tvdec_i2c_regs`

## Requirements
- R1: After reset the fields are: level 0x9, both test bits 0, both separation trims 0x1F, external select, program select, forced mono and program condition 0, unmute 1, both volumes 0x3F. The data line is not driven.
- R2: An address byte 0x84 or 0x85 is acknowledged. Any other address byte is not acknowledged, and the bytes after it up to the next START or STOP change nothing and are not acknowledged.
- R3: In a write, the byte after the address is the sub-address. Only its low four bits are kept, and its upper four bits have no effect.
- R4: Each data byte is stored at the current sub-address, which then increments modulo 16, so a burst from sub-address 14 goes on to 15, then 0, then 1.
- R5: The register fields are. Sub-address 0: bit 7 DAC test, bit 6 monitor test, bits 3:0 level. Sub-address 1: bits 5:0 high-frequency separation. Sub-address 2: bits 5:0 wide-band separation. Sub-address 3: bit 4 external select, bit 3 program condition, bit 2 unmute, bit 1 program select, bit 0 forced mono. Sub-address 4: bits 5:0 left volume. Sub-address 5: bits 5:0 right volume. Bits outside these fields are discarded.
- R6: Data bytes written to sub-addresses 6 to 15 are acknowledged and change no output.
- R7: A read returns the status byte: bit 7 program detected, bit 6 program noise, bit 1 stereo detected, bit 0 reset flag, all other bits 0. The detector inputs are synchronised and sampled when the byte starts.
- R8: The reset flag is 1 after reset. It clears once a status byte has been read to the end, and it does not set again without a reset.
- R9: The block pulls the data line low only to acknowledge and to send 0 bits of read data. It changes its drive only while the clock is low, and it releases the line when the master sends its own bits.
- R10: A repeated START begins a new address phase at once and keeps the registers written so far. A STOP ends the transfer and releases the line.
- R11: When the master acknowledges a status byte, the block sends another status byte. After a not-acknowledge it sends nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| det_stereo_i | input | 1 | Stereo pilot detected (asynchronous) |
| det_sap_i | input | 1 | Second program carrier detected (asynchronous) |
| det_noise_i | input | 1 | Second program noise detected (asynchronous) |
| lvl_adj_o | output | 4 | Input level trim |
| tst_dac_o | output | 1 | DAC test mode |
| tst_mon_o | output | 1 | Filter monitor test mode |
| sep_hf_o | output | 6 | High-frequency separation trim |
| sep_wb_o | output | 6 | Wide-band separation trim |
| ext_sel_o | output | 1 | External input select |
| sap_sel_o | output | 1 | Second program output select |
| mono_force_o | output | 1 | Forced mono |
| unmute_o | output | 1 | Speaker output enabled (0 mutes) |
| sap_cond_o | output | 1 | Select second program even when none is detected |
| vol_l_o | output | 6 | Left volume |
| vol_r_o | output | 6 | Right volume |

## Verification
Every sub-address from 0 to 15 gets a single-byte write, with junk in the upper nibble of the sub-address byte and a different data value each time. This shows that each field lands in the right bits and that writes to unused slots or unused bits are lost. All-ones and all-zeros bursts, a burst that runs past sub-address 5 and one that wraps past 15, tell correct increment from stuck or non-wrapping pointers. All eight detector combinations are read back, which pins each status bit position and shows the reset flag clearing. Wrong addresses, repeated STARTs, early STOPs and acknowledged multi-byte reads test the protocol edges.

// File: rtl/tvdec_i2c_pkg.sv
package tvdec_i2c_pkg;

   localparam int BYTE_W  = 8;
   localparam int REG_CNT = 6;

   // status byte bit positions decoded by host software
   localparam int STB_POR    = 0;
   localparam int STB_STEREO = 1;
   localparam int STB_NOISE  = 6;
   localparam int STB_SAP    = 7;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_SUB,
      PH_WR,
      PH_RD,
      PH_SKIP
   } phase_e;

   // writable bits per register slot
   function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
      case (idx)
         0:       return 8'hCF;
         1, 2:    return 8'h3F;
         3:       return 8'h1F;
         4, 5:    return 8'h3F;
         default: return 8'h00;
      endcase
   endfunction

   // value loaded on reset per register slot
   function automatic logic [BYTE_W-1:0] reg_reset(input int idx);
      case (idx)
         0:       return 8'h09;
         1, 2:    return 8'h1F;
         3:       return 8'h04;
         4, 5:    return 8'h3F;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/tvdec_i2c_sync.sv
module tvdec_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tvdec_i2c_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_chain, sda_chain;
   logic              scl_q, sda_q;
   logic              scl_s, sda_s;

   assign scl_s = scl_chain[STAGES-1];
   assign sda_s = sda_chain[STAGES-1];

   // idle bus is high, so the chain resets to ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_q     <= 1'b1;
         sda_q     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[STAGES-2:0], scl_i};
         sda_chain <= {sda_chain[STAGES-2:0], sda_i};
         scl_q     <= scl_s;
         sda_q     <= sda_s;
      end
   end

   assign sda_lvl   = sda_s;
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tvdec_i2c_status.sv
module tvdec_i2c_status
   import tvdec_i2c_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              det_stereo_i,
   input  logic              det_sap_i,
   input  logic              det_noise_i,
   input  logic              rd_done,
   output logic [BYTE_W-1:0] stat_byte,
   output logic              por_flag
);

   localparam int N_DET = 3;

   logic [N_DET-1:0] det_raw, det_s;

   assign det_raw = {det_noise_i, det_sap_i, det_stereo_i};

   for (genvar d = 0; d < N_DET; d++) begin : g_det
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], det_raw[d]};
      end
      assign det_s[d] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       por_flag <= 1'b1;
      else if (rd_done) por_flag <= 1'b0;
   end

   always_comb begin
      stat_byte             = '0;
      stat_byte[STB_POR]    = por_flag;
      stat_byte[STB_STEREO] = det_s[0];
      stat_byte[STB_SAP]    = det_s[1];
      stat_byte[STB_NOISE]  = det_s[2];
   end

endmodule

// File: rtl/tvdec_i2c_regfile.sv
module tvdec_i2c_regfile
   import tvdec_i2c_pkg::*;
#(
   parameter int NUM_REGS = REG_CNT,
   parameter int AW       = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_idx,
   input  logic [BYTE_W-1:0]          wr_data,
   output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

   if (NUM_REGS > (1 << AW)) begin : g_bad_depth
      $error("tvdec_i2c_regfile: NUM_REGS exceeds sub-address space");
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [BYTE_W-1:0] MASK = reg_mask(i);
      localparam logic [BYTE_W-1:0] RSTV = reg_reset(i);
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            q <= RSTV;
         else if (wr_en && wr_idx == AW'(i))    q <= wr_data & MASK;
      end
      assign regs_flat[i*BYTE_W +: BYTE_W] = q;
   end

endmodule

// File: rtl/tvdec_i2c_engine.sv
module tvdec_i2c_engine
   import tvdec_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h42,
   parameter int         AW       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] stat_byte,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [AW-1:0]     wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic              rd_done
);

   localparam logic [3:0] LAST_BIT = 4'd8;
   localparam logic [3:0] ACK_BIT  = 4'd9;

   phase_e            phase;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic              oe_q, is_read, mst_nack;
   logic [AW-1:0]     ptr;
   logic              active, quiet;

   assign active = (phase != PH_IDLE) && (phase != PH_SKIP);
   assign quiet  = active && !start_det && !stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         oe_q     <= 1'b0;
         is_read  <= 1'b0;
         mst_nack <= 1'b1;
         ptr      <= '0;
      end else if (stop_det) begin
         phase   <= PH_IDLE;
         bit_cnt <= '0;
         oe_q    <= 1'b0;
      end else if (start_det) begin
         phase   <= PH_ADDR;
         bit_cnt <= '0;
         oe_q    <= 1'b0;
      end else if (active) begin
         if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt < LAST_BIT) rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
            if (phase == PH_RD && bit_cnt == LAST_BIT) mst_nack <= sda_lvl;
         end else if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
               // eight bits in: decide acknowledge
               case (phase)
                  PH_ADDR: begin
                     if (rx_sh[7:1] == DEV_ADDR) begin
                        oe_q    <= 1'b1;
                        is_read <= rx_sh[0];
                     end else begin
                        phase <= PH_SKIP;
                     end
                  end
                  PH_SUB: begin
                     ptr  <= rx_sh[AW-1:0];
                     oe_q <= 1'b1;
                  end
                  PH_WR: begin
                     ptr  <= ptr + 1'b1;
                     oe_q <= 1'b1;
                  end
                  default: oe_q <= 1'b0;
               endcase
            end else if (bit_cnt == ACK_BIT) begin
               // ninth clock over: open the next byte
               bit_cnt <= '0;
               oe_q    <= 1'b0;
               case (phase)
                  PH_ADDR: begin
                     if (is_read) begin
                        phase <= PH_RD;
                        oe_q  <= ~stat_byte[BYTE_W-1];
                        tx_sh <= {stat_byte[BYTE_W-2:0], 1'b0};
                     end else begin
                        phase <= PH_SUB;
                     end
                  end
                  PH_SUB: phase <= PH_WR;
                  PH_RD: begin
                     if (!mst_nack) begin
                        oe_q  <= ~stat_byte[BYTE_W-1];
                        tx_sh <= {stat_byte[BYTE_W-2:0], 1'b0};
                     end else begin
                        phase <= PH_SKIP;
                     end
                  end
                  default: ;
               endcase
            end else if (phase == PH_RD && bit_cnt != 4'd0) begin
               oe_q  <= ~tx_sh[BYTE_W-1];
               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign sda_oe  = oe_q;
   assign wr_idx  = ptr;
   assign wr_data = rx_sh;
   assign wr_en   = quiet && scl_fall && phase == PH_WR && bit_cnt == LAST_BIT;
   assign rd_done = quiet && scl_rise && phase == PH_RD && bit_cnt == LAST_BIT;

endmodule

// File: rtl/tvdec_i2c_regs.sv
module tvdec_i2c_regs
   import tvdec_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h42,
   parameter int         SYNC_STAGES = 2,
   parameter int         SUB_W       = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic       det_stereo_i,
   input  logic       det_sap_i,
   input  logic       det_noise_i,
   output logic [3:0] lvl_adj_o,
   output logic       tst_dac_o,
   output logic       tst_mon_o,
   output logic [5:0] sep_hf_o,
   output logic [5:0] sep_wb_o,
   output logic       ext_sel_o,
   output logic       sap_sel_o,
   output logic       mono_force_o,
   output logic       unmute_o,
   output logic       sap_cond_o,
   output logic [5:0] vol_l_o,
   output logic [5:0] vol_r_o
);

   localparam int FLAT_W = REG_CNT * BYTE_W;

   if (SUB_W < 3 || SUB_W > BYTE_W) begin : g_bad_sub
      $error("tvdec_i2c_regs: SUB_W must lie in 3..8");
   end

   logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic [BYTE_W-1:0] stat_byte, wr_data;
   logic              por_flag, rd_done, wr_en;
   logic [SUB_W-1:0]  wr_idx;
   logic [FLAT_W-1:0] regs_flat;
   logic [BYTE_W-1:0] r0, r1, r2, r3, r4, r5;

   tvdec_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tvdec_i2c_status #(.STAGES(SYNC_STAGES)) u_stat (
      .clk          (clk),
      .rst_n        (rst_n),
      .det_stereo_i (det_stereo_i),
      .det_sap_i    (det_sap_i),
      .det_noise_i  (det_noise_i),
      .rd_done      (rd_done),
      .stat_byte    (stat_byte),
      .por_flag     (por_flag)
   );

   tvdec_i2c_engine #(.DEV_ADDR(DEV_ADDR), .AW(SUB_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .stat_byte (stat_byte),
      .sda_oe    (sda_oe_o),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_done   (rd_done)
   );

   tvdec_i2c_regfile #(.NUM_REGS(REG_CNT), .AW(SUB_W)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .regs_flat (regs_flat)
   );

   assign {r5, r4, r3, r2, r1, r0} = regs_flat;

   assign tst_dac_o    = r0[7];
   assign tst_mon_o    = r0[6];
   assign lvl_adj_o    = r0[3:0];
   assign sep_hf_o     = r1[5:0];
   assign sep_wb_o     = r2[5:0];
   assign ext_sel_o    = r3[4];
   assign sap_cond_o   = r3[3];
   assign unmute_o     = r3[2];
   assign sap_sel_o    = r3[1];
   assign mono_force_o = r3[0];
   assign vol_l_o      = r4[5:0];
   assign vol_r_o      = r5[5:0];

   logic unused_bits;
   assign unused_bits = ^{r0[5:4], r1[7:6], r2[7:6], r3[7:5], r4[7:6], r5[7:6]};

endmodule

// File: rtl/tvdec_i2c_chk.sv
module tvdec_i2c_chk #(
   parameter int SUB_W    = 4,
   parameter int FLAT_W   = 48,
   parameter int NUM_REGS = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe_o,
   input logic              stop_det,
   input logic              wr_en,
   input logic [SUB_W-1:0]  wr_idx,
   input logic [FLAT_W-1:0] regs_flat,
   input logic              por_flag,
   input logic              rd_done
);

   AST_DRIVE_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !$past(scl_i)); // R9

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o); // R10

   AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (wr_idx == SUB_W'($past(wr_idx) + 1'b1))); // R4

   AST_UNUSED_SLOT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_idx) >= NUM_REGS) |=> $stable(regs_flat)); // R6

   AST_POR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(por_flag)); // R8

   AST_POR_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(por_flag) |-> $past(rd_done)); // R8

endmodule

bind tvdec_i2c_regs tvdec_i2c_chk #(
   .SUB_W    (SUB_W),
   .FLAT_W   (FLAT_W),
   .NUM_REGS (tvdec_i2c_pkg::REG_CNT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_oe_o  (sda_oe_o),
   .stop_det  (stop_det),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .regs_flat (regs_flat),
   .por_flag  (por_flag),
   .rd_done   (rd_done)
);

// File: tb/tvdec_i2c_regs_test.sv
module tvdec_i2c_regs_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_line;
   logic sda_oe;
   logic st_stereo = 1'b0, st_sap = 1'b0, st_noise = 1'b0;
   logic [3:0] lvl;
   logic       tdac, tmon, ext, ssel, mono, unm, scond;
   logic [5:0] shf, swb, vl, vr;

   assign sda_line = ~(m_low | sda_oe);

   tvdec_i2c_regs uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .det_stereo_i(st_stereo), .det_sap_i(st_sap), .det_noise_i(st_noise),
      .lvl_adj_o(lvl), .tst_dac_o(tdac), .tst_mon_o(tmon), .sep_hf_o(shf),
      .sep_wb_o(swb), .ext_sel_o(ext), .sap_sel_o(ssel), .mono_force_o(mono),
      .unmute_o(unm), .sap_cond_o(scond), .vol_l_o(vl), .vol_r_o(vr)
   );

   int checks = 0;
   int errors = 0;
   localparam int Q = 100;

   logic [7:0] model [6];
   logic [7:0] msk   [6];

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] observed(input int r);
      case (r)
         0: return {tdac, tmon, 2'b00, lvl};
         1: return {2'b00, shf};
         2: return {2'b00, swb};
         3: return {3'b000, ext, scond, unm, ssel, mono};
         4: return {2'b00, vl};
         default: return {2'b00, vr};
      endcase
   endfunction

   task automatic compare_all(input string req);
      for (int r = 0; r < 6; r++) check(req, observed(r), model[r]);
   endtask

   task automatic bus_start();
      m_low = 1'b1; #Q; scl = 1'b0; #Q;
   endtask

   task automatic bus_rstart();
      m_low = 1'b0; #Q; scl = 1'b1; #Q; m_low = 1'b1; #Q; scl = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      m_low = 1'b1; #Q; scl = 1'b1; #Q; m_low = 1'b0; #Q; #Q;
   endtask

   // send one byte; ack=1 when the slave pulled the line low in clock nine
   task automatic tx_byte(input logic [7:0] b, output logic ack);
      int clash = 0;
      for (int i = 7; i >= 0; i--) begin
         m_low = ~b[i]; #Q; scl = 1'b1; #Q;
         if (sda_line !== b[i]) clash++;
         scl = 1'b0; #Q;
      end
      m_low = 1'b0; #Q; scl = 1'b1; #Q;
      ack = ~sda_line;
      scl = 1'b0; #Q;
      check("R9 line released while master sends", clash, 0);
   endtask

   task automatic rx_byte(input logic mack, output logic [7:0] d);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         #Q; scl = 1'b1; #Q; d[i] = sda_line; scl = 1'b0; #Q;
      end
      m_low = mack; #Q; scl = 1'b1; #Q; scl = 1'b0; #Q; m_low = 1'b0;
   endtask

   task automatic model_write(input int sub, input logic [7:0] d);
      if (sub % 16 < 6) model[sub % 16] = d & msk[sub % 16];
   endtask

   // write n bytes starting at sub-address byte sb, data d0 + k*step
   task automatic wr_burst(input string req, input logic [7:0] sb, input int n,
                           input logic [7:0] d0, input logic [7:0] step);
      logic ack;
      logic [7:0] d;
      bus_start();
      tx_byte(8'h84, ack); check({req, " R2 write address ack"}, ack, 1);
      tx_byte(sb, ack);    check({req, " R3 sub-address ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         d = d0 + 8'(k) * step;
         tx_byte(d, ack); check({req, " data ack"}, ack, 1);
         model_write(int'(sb[3:0]) + k, d);
      end
      bus_stop();
   endtask

   task automatic rd_status(input string req, input logic [7:0] exp);
      logic ack;
      logic [7:0] d;
      bus_start();
      tx_byte(8'h85, ack); check({req, " R2 read address ack"}, ack, 1);
      rx_byte(1'b0, d);
      check(req, d, exp);
      bus_stop();
   endtask

   initial begin
      #1_900_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] d, e;
      msk = '{8'hCF, 8'h3F, 8'h3F, 8'h1F, 8'h3F, 8'h3F};
      model = '{8'h09, 8'h1F, 8'h1F, 8'h04, 8'h3F, 8'h3F};
      #53; rst_n = 1'b1; #200;

      // R1 reset state
      compare_all("R1 reset value");
      check("R1 line idle after reset", sda_oe, 0);

      // R3 R5 R6: every sub-address with junk in the upper nibble
      for (int s = 0; s < 16; s++) begin
         wr_burst(s < 6 ? "R5 field sweep" : "R6 unused slot",
                  {4'(s * 5 + 3), 4'(s)}, 1, 8'(s * 53 + 150), 8'h00);
         compare_all(s < 6 ? "R3 R5 fields after write" : "R6 outputs unchanged");
      end

      // R5 masking with all ones then all zeros
      wr_burst("R5 ones", 8'h00, 6, 8'hFF, 8'h00);
      compare_all("R5 all ones masked");
      wr_burst("R5 zeros", 8'hF0, 6, 8'h00, 8'h00);
      compare_all("R5 all zeros");

      // R4 burst past the last slot, and wrap from 14
      wr_burst("R4 burst", 8'h04, 5, 8'h21, 8'h11);
      compare_all("R4 auto increment");
      wr_burst("R4 wrap", 8'h0E, 4, 8'h3C, 8'h07);
      compare_all("R4 wrap modulo 16");

      // R2 wrong addresses
      bus_start();
      tx_byte(8'h86, ack); check("R2 foreign write address nack", ack, 0);
      tx_byte(8'h00, ack); check("R2 skipped byte nack", ack, 0);
      tx_byte(8'hA5, ack); check("R2 skipped byte nack", ack, 0);
      bus_stop();
      compare_all("R2 foreign transfer ignored");
      bus_start();
      tx_byte(8'h87, ack); check("R2 foreign read address nack", ack, 0);
      bus_stop();

      // R7 R8: first read carries the reset flag
      st_stereo = 1'b1; st_noise = 1'b1; st_sap = 1'b0; #200;
      rd_status("R7 R8 first read with reset flag", 8'h43);
      for (int c = 0; c < 8; c++) begin
         st_stereo = c[0]; st_sap = c[1]; st_noise = c[2]; #200;
         e = {c[1] ? 1'b1 : 1'b0, c[2] ? 1'b1 : 1'b0, 4'b0000, c[0] ? 1'b1 : 1'b0, 1'b0};
         rd_status("R7 R8 status layout, flag cleared", e);
      end

      // R11 acknowledged read continues
      st_stereo = 1'b0; st_sap = 1'b1; st_noise = 1'b0; #200;
      bus_start();
      tx_byte(8'h85, ack); check("R11 read address ack", ack, 1);
      rx_byte(1'b1, d); check("R11 first status byte", d, 8'h80);
      rx_byte(1'b1, d); check("R11 second status byte", d, 8'h80);
      rx_byte(1'b0, d); check("R11 third status byte", d, 8'h80);
      check("R11 line released after nack", sda_oe, 0);
      bus_stop();

      // R10 repeated start from write into read
      bus_start();
      tx_byte(8'h84, ack); check("R10 address ack", ack, 1);
      tx_byte(8'h05, ack); check("R10 sub ack", ack, 1);
      tx_byte(8'h12, ack); check("R10 data ack", ack, 1);
      model_write(5, 8'h12);
      bus_rstart();
      tx_byte(8'h85, ack); check("R10 read after repeated start ack", ack, 1);
      rx_byte(1'b0, d); check("R10 status after repeated start", d, 8'h80);
      bus_stop();
      compare_all("R10 write kept across repeated start");

      // R10 repeated start into a fresh write
      bus_start();
      tx_byte(8'h84, ack);
      tx_byte(8'h02, ack);
      bus_rstart();
      tx_byte(8'h84, ack); check("R10 second address ack", ack, 1);
      tx_byte(8'h01, ack); check("R10 new sub ack", ack, 1);
      tx_byte(8'h2A, ack); check("R10 data ack", ack, 1);
      model_write(1, 8'h2A);
      bus_stop();
      compare_all("R10 fresh sub-address after repeated start");

      // R10 stop right after the sub-address
      bus_start();
      tx_byte(8'h84, ack);
      tx_byte(8'h04, ack);
      bus_stop();
      compare_all("R10 early stop writes nothing");
      check("R10 line idle after stop", sda_oe, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule